// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store instruction into a stream of per-element memory requests. The instruction arrives through a start handshake that carries an addressing mode, a base address, a stride or step value and an element count. The generator then issues one request per element, in element order. Each request carries a byte address, the number of the interleaved memory bank that holds that address, and the element number. Memory is split across a power-of-two number of banks, and the bank is taken from the word address. Each bank stays occupied for a fixed number of cycles after it takes a request. A request whose bank is still occupied waits. It is never skipped and never overtaken by a later element.

Four modes are provided. Unit-stride mode steps the address by the element size of 8 bytes. Constant-stride mode steps it by a signed byte stride. Indexed mode (gather or scatter) adds one entry of an incoming index stream to the base. Index-generation mode produces the values 0, m, 2m and so on, where m is the step value. It uses no memory bank, and it is used to build index vectors for a later indexed access.

Both the request output and the index input are valid/ready streams. A producer must not retract `idx_valid` or change `idx_data` until the index is taken. While `req_valid` is high and `req_ready` is low, the generator holds the request unchanged. The one exception is an indexed request whose index input is itself stalled.

Top module: `vec_addr_gen`

## Requirements
- R1: `start_ready` is high exactly when no instruction is in progress. A start is accepted on a clock edge where `start_valid` and `start_ready` are both high. At that edge the block captures `start_mode`, `start_base`, `start_stride` and `start_len`.
- R2: The effective element count is `start_len` clamped to MAX_VL (64). A count of zero issues no request at all.
- R3: In unit-stride mode (`start_mode` = 0), element i has address base + 8*i, taken modulo 2^32.
- R4: In constant-stride mode (`start_mode` = 1), element i has address base + i*stride. The stride is a byte count in two's complement, and the address is taken modulo 2^32.
- R5: In indexed mode (`start_mode` = 2), element i has address base + the i-th accepted index. Exactly one index is taken (`idx_valid` and `idx_ready` both high) per accepted request. `idx_ready` stays low in every other mode and while the block is idle.
- R6: In index-generation mode (`start_mode` = 3), element i carries the value i*stride in `req_addr`. Its requests neither wait on a bank nor occupy one.
- R7: `req_bank` equals `req_addr[5:3]`, which is the word address modulo 8.
- R8: A bank that accepts a memory request at a clock edge refuses further requests until LATENCY (4) edges later. While the current element's bank is refusing, `req_valid` is low. Otherwise `req_valid` is high whenever an element is pending and, in indexed mode, an index is present. Elements are issued in order 0..n-1 and `req_elem` equals i.
- R9: While `req_valid` is high and `req_ready` is low, the request stays asserted and its address, bank and element number do not change (non-indexed modes).
- R10: `done` is high for the single cycle after the edge that accepts the last request. With a zero count, `done` is high for the single cycle after the start edge. While `done` is high, `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Instruction offered |
| start_ready | output | 1 | Generator idle, start can be taken |
| start_mode | input | 2 | 0 unit, 1 stride, 2 indexed, 3 index generation |
| start_base | input | 32 | Base byte address |
| start_stride | input | 32 | Byte stride, or step for index generation |
| start_len | input | 7 | Requested element count |
| idx_valid | input | 1 | Index entry present |
| idx_ready | output | 1 | Index entry taken this cycle |
| idx_data | input | 32 | Index entry (byte offset) |
| req_valid | output | 1 | Element request present |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | 32 | Element byte address or generated value |
| req_bank | output | 3 | Target bank |
| req_elem | output | 6 | Element number |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps its own model of every bank's occupancy and checks, cycle by cycle, that `req_valid` rises exactly when the target bank is free. A design with an off-by-one occupancy count would either issue too early or add a bubble, and that shows on strides of 32 bytes, which revisit one bank every other element. Counts of zero and above 64 are driven directly: a missing clamp issues extra elements, and a design that mishandles zero hangs or issues a spurious element. Random back-pressure and gaps in the index stream test that a stalled request neither advances nor drops an index, while index-generation runs confirm that they never occupy a bank.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    VM_UNIT   = 2'd0,
    VM_STRIDE = 2'd1,
    VM_INDEX  = 2'd2,
    VM_IOTA   = 2'd3
  } vmode_e;
endpackage

// File: rtl/vag_bank_tracker.sv
module vag_bank_tracker #(
  parameter int unsigned NBANK   = 8,
  parameter int unsigned LATENCY = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     claim,
  input  logic [$clog2(NBANK)-1:0] claim_bank,
  output logic [NBANK-1:0]         busy
);
  localparam int unsigned CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(LATENCY - 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (claim && claim_bank == b) cnt <= RELOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
    assign busy[b] = (cnt != '0);
  end

  // R8: a bank just claimed cannot be claimed again on the next edge
  if (LATENCY > 1) begin : g_gap_chk
    p_reuse_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      claim |=> !(claim && claim_bank == $past(claim_bank)));
  end
endmodule

// File: rtl/vag_addr_unit.sv
module vag_addr_unit
  import vag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned ESIZE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  vmode_e        mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] idx_data,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] off_q;
  logic [AW-1:0] step;

  assign step = (mode == VM_UNIT) ? AW'(ESIZE) : stride;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else if (load) off_q <= '0;
    else if (advance) off_q <= off_q + step;
  end

  always_comb begin
    unique case (mode)
      VM_INDEX: addr = base + idx_data;
      VM_IOTA:  addr = off_q;
      default:  addr = base + off_q;
    endcase
  end

  // R3/R4: without an advance the running offset holds
  p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !advance |=> $stable(off_q));
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned MAX_VL  = 64,
  parameter int unsigned NBANK   = 8,
  parameter int unsigned ESIZE   = 8,
  parameter int unsigned LATENCY = 4,
  localparam int unsigned LW = $clog2(MAX_VL + 1),
  localparam int unsigned EW = $clog2(MAX_VL),
  localparam int unsigned BW = $clog2(NBANK),
  localparam int unsigned SH = $clog2(ESIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [1:0]    start_mode,
  input  logic [AW-1:0] start_base,
  input  logic [AW-1:0] start_stride,
  input  logic [LW-1:0] start_len,
  input  logic          idx_valid,
  output logic          idx_ready,
  input  logic [AW-1:0] idx_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [BW-1:0] req_bank,
  output logic [EW-1:0] req_elem,
  output logic          done
);
  logic          active_q, done_q;
  vmode_e        mode_q;
  logic [AW-1:0] base_q, stride_q;
  logic [LW-1:0] len_q, len_eff;
  logic [EW-1:0] elem_q;
  logic [NBANK-1:0] busy;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] cur_bank;
  logic start_fire, fire, last, mem_mode, src_ok, bank_ok;

  assign len_eff    = (start_len > LW'(MAX_VL)) ? LW'(MAX_VL) : start_len;
  assign start_ready = !active_q;
  assign start_fire = start_valid && start_ready;
  assign cur_bank   = cur_addr[SH +: BW];
  assign mem_mode   = (mode_q != VM_IOTA);
  assign src_ok     = (mode_q != VM_INDEX) || idx_valid;
  assign bank_ok    = !mem_mode || !busy[cur_bank];
  assign req_valid  = active_q && src_ok && bank_ok;
  assign fire       = req_valid && req_ready;
  assign idx_ready  = active_q && (mode_q == VM_INDEX) && bank_ok && req_ready;
  assign last       = (LW'(elem_q) + 1'b1) == len_q;

  assign req_addr = cur_addr;
  assign req_bank = cur_bank;
  assign req_elem = elem_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      mode_q   <= VM_UNIT;
      base_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      elem_q   <= '0;
    end else begin
      done_q <= (start_fire && len_eff == '0) || (fire && last);
      if (start_fire) begin
        mode_q   <= vmode_e'(start_mode);
        base_q   <= start_base;
        stride_q <= start_stride;
        len_q    <= len_eff;
        elem_q   <= '0;
        active_q <= (len_eff != '0);
      end else if (fire) begin
        elem_q <= elem_q + 1'b1;
        if (last) active_q <= 1'b0;
      end
    end
  end

  vag_addr_unit #(.AW(AW), .ESIZE(ESIZE)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start_fire), .advance(fire),
    .mode(mode_q), .base(base_q), .stride(stride_q), .idx_data(idx_data),
    .addr(cur_addr)
  );

  vag_bank_tracker #(.NBANK(NBANK), .LATENCY(LATENCY)) u_banks (
    .clk(clk), .rst_n(rst_n), .claim(fire && mem_mode), .claim_bank(cur_bank),
    .busy(busy)
  );

  // R2: element numbers stay below the captured count
  p_elem_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (LW'(req_elem) < len_q));
  // R8: an accepted non-final element is followed by the next element number
  p_elem_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> req_elem == $past(req_elem) + 1'b1);
  // R9: a refused request is held unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && mode_q != VM_INDEX |=>
      req_valid && $stable(req_addr) && $stable(req_elem) && $stable(req_bank));
  // R10: no request is presented during the completion pulse
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
  // R5: index taken only together with an accepted request
  p_idx_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && idx_ready |-> fire);
endmodule

// File: tb/vec_addr_gen_test.sv
`timescale 1ns/1ps
module vec_addr_gen_test;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [1:0] start_mode = '0;
  logic [31:0] start_base = '0, start_stride = '0;
  logic [6:0] start_len = '0;
  logic idx_valid = 1'b0, idx_ready;
  logic [31:0] idx_data = '0;
  logic req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [2:0] req_bank;
  logic [5:0] req_elem;
  logic done;

  always #2 clk = ~clk;

  vec_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_mode(start_mode), .start_base(start_base), .start_stride(start_stride),
    .start_len(start_len), .idx_valid(idx_valid), .idx_ready(idx_ready),
    .idx_data(idx_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bank(req_bank), .req_elem(req_elem), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int bcnt[8];
  bit ex_active = 0, ex_done = 0, idx_hold = 0;
  int op_mode = 0, op_len = 0, n_fired = 0;
  logic [31:0] op_base = '0, op_stride = '0;
  logic [31:0] idx_arr[64];
  bit sv = 0;
  int rdy_pct = 100, idx_pct = 100;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(int m, logic [31:0] b, logic [31:0] s, int i, logic [31:0] ix);
    case (m)
      0: return b + 32'(i) * 32'd8;
      1: return b + 32'(i) * s;
      2: return b + ix;
      default: return 32'(i) * s;
    endcase
  endfunction

  task automatic cycle();
    logic [31:0] ea;
    bit ev, rdy, fire, acc;
    @(negedge clk);
    rdy = ($urandom % 100) < rdy_pct;
    req_ready = rdy;
    start_valid = sv;
    if (ex_active && op_mode == 2) begin
      if (!idx_hold && (($urandom % 100) < idx_pct)) idx_hold = 1;
      idx_valid = idx_hold;
      idx_data = idx_arr[n_fired];
    end else begin
      idx_valid = 0;
      idx_data = $urandom;
    end
    #1;
    ea = exp_addr(op_mode, op_base, op_stride, n_fired, idx_arr[n_fired]);
    ev = ex_active && (op_mode != 2 || idx_valid) && (op_mode == 3 || bcnt[ea[5:3]] == 0);
    chk(start_ready == !ex_active, "R1 start_ready", 32'(start_ready), 32'(!ex_active));
    chk(req_valid == ev, "R8 req_valid vs bank model", 32'(req_valid), 32'(ev));
    chk(done == ex_done, "R10 done", 32'(done), 32'(ex_done));
    if (ex_active && req_valid) begin
      chk(req_addr == ea, op_mode == 0 ? "R3 addr" : op_mode == 1 ? "R4 addr" :
          op_mode == 2 ? "R5 addr" : "R6 value", req_addr, ea);
      chk(req_bank == ea[5:3], "R7 bank", 32'(req_bank), 32'(ea[5:3]));
      chk(32'(req_elem) == 32'(n_fired), "R8 elem", 32'(req_elem), 32'(n_fired));
    end
    if (!(ex_active && op_mode == 2))
      chk(idx_ready == 0, "R5 idx_ready idle", 32'(idx_ready), 0);
    else if (idx_valid)
      chk(idx_ready == (ev && rdy), "R5 idx consume", 32'(idx_ready), 32'(ev && rdy));
    fire = ev && rdy;
    acc = sv && !ex_active;
    ex_done = 0;
    for (int b = 0; b < 8; b++) if (bcnt[b] > 0) bcnt[b]--;
    if (fire) begin
      if (op_mode != 3) bcnt[ea[5:3]] = LAT - 1;
      if (op_mode == 2) idx_hold = 0;
      n_fired++;
      if (n_fired == op_len) begin ex_active = 0; ex_done = 1; end
    end
    if (acc) begin
      op_mode = start_mode; op_base = start_base; op_stride = start_stride;
      op_len = (start_len > 64) ? 64 : int'(start_len);
      n_fired = 0; idx_hold = 0;
      ex_active = (op_len != 0);
      ex_done = (op_len == 0);
    end
  endtask

  task automatic run_op(input int m, input logic [31:0] b, input logic [31:0] s, input int len);
    int guard = 0;
    int want;
    for (int i = 0; i < 64; i++) idx_arr[i] = $urandom;
    start_mode = 2'(m); start_base = b; start_stride = s; start_len = 7'(len);
    want = (len > 64) ? 64 : len;
    sv = 1; cycle(); sv = 0;
    while (ex_active && guard < 4000) begin cycle(); guard++; end
    chk(!ex_active, "R2 op completes", 32'(ex_active), 0);
    chk(n_fired == want, "R2 request count", 32'(n_fired), 32'(want));
    cycle(); // done pulse checked here (R10)
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int b = 0; b < 8; b++) bcnt[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(start_ready == 1, "R1 reset start_ready", 32'(start_ready), 1);
    chk(req_valid == 0, "R8 reset req_valid", 32'(req_valid), 0);
    chk(done == 0, "R10 reset done", 32'(done), 0);
    // directed corners
    run_op(0, 32'h1000, 0, 64);          // R3 full length, no stall expected
    run_op(1, 32'h2000, 32'd32, 12);     // R8 word stride 4: bank conflicts
    run_op(1, 32'h3000, 32'd24, 20);     // R4 stride coprime to bank count
    run_op(1, 32'h4008, 32'hFFFF_FFF8, 9); // R4 negative stride
    run_op(0, 32'h5000, 0, 0);           // R2 zero length
    run_op(0, 32'hFFFF_FFF0, 0, 100);    // R2 clamp, R3 wrap
    run_op(3, 0, 32'd12, 10);            // R6 index generation
    run_op(2, 32'h8000, 0, 16);          // R5 gather
    // random mix with back-pressure
    rdy_pct = 60; idx_pct = 70;
    for (int k = 0; k < 30; k++)
      run_op($urandom % 4, $urandom, {$urandom} % 8 == 0 ? 32'd8 : 32'($urandom % 128) << 3,
             $urandom % 80);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule